// File: doc/BRIEF.md
# Link pin mode multiplexer

This block stands between a byte-wide link transmitter, a link receiver and the eleven physical pins those two engines use. Configuration inputs give each direction its own enable bit and its own 2-bit mode field. From these the block decides, once per clock, what drives each output pin and what each engine sees. The transmit pins can carry the transmitter's data and frame or a software-supplied pattern. The receive wait pins can carry the receiver's wait requests or a software pattern. The receiver can be fed from the external pins or, for self-test, straight from the transmitter's data and frame outputs.

All incoming pins pass through a synchronizer. The synchronized bundle is copied every cycle into a snapshot register, so software can sample the pin levels. Every output of the block is a flop. A change on a configuration input therefore shows up on the pins at the first clock edge after it.

The byte width and the synchronizer depth are parameters. The bundle width follows from the byte width: data bits, then frame, read-wait and write-wait, in that order from bit 0 upward.

Top module: `linkpin_mux`

## Requirements
- R1: While `rst` is high at a rising edge, every output (`pin_out`, `to_rx_data`, `to_rx_frame`, `to_tx_rd_wait`, `to_tx_wr_wait`, `din_snap`) is 0 after that edge, and so are the synchronizer stages.
- R2: With `cfg_tx_en`=1 and `cfg_tx_mode` equal to 00, 10 or 11 (10 and 11 are reserved and act as 00), `pin_out[7:0]` and `pin_out[8]` equal `tx_core_data` and `tx_core_frame` as sampled at the previous edge.
- R3: With `cfg_tx_en`=1 and `cfg_tx_mode`=01 (GPIO), `pin_out[8:0]` equals `sw_dout[8:0]` as sampled at the previous edge.
- R4: With `cfg_tx_en`=0, `pin_out[8:0]`, `to_tx_rd_wait` and `to_tx_wr_wait` are 0 after the next edge.
- R5: With `cfg_rx_en`=1 and `cfg_rx_mode` equal to 00 or 11 (11 is reserved and acts as 00), `pin_out[9]` and `pin_out[10]` equal `rx_core_rd_wait` and `rx_core_wr_wait` from the previous edge. `to_rx_data` and `to_rx_frame` equal `pin_in[7:0]` and `pin_in[8]` delayed by SYNC_STAGES+1 edges.
- R6: With `cfg_rx_en`=1 and `cfg_rx_mode`=01 (GPIO), `pin_out[9]` and `pin_out[10]` equal `sw_dout[9]` and `sw_dout[10]` from the previous edge. The receiver is still fed from the synchronized pins as in R5.
- R7: With `cfg_rx_en`=1 and `cfg_rx_mode`=10 (loopback), `to_rx_data` and `to_rx_frame` equal `tx_core_data` and `tx_core_frame` from the previous edge, whatever the transmit enable or mode. The wait pins follow the receiver as in R5.
- R8: With `cfg_rx_en`=0, `to_rx_data`, `to_rx_frame`, `pin_out[9]` and `pin_out[10]` are 0 after the next edge.
- R9: With `cfg_tx_en`=1, `to_tx_rd_wait` and `to_tx_wr_wait` equal `pin_in[9]` and `pin_in[10]` delayed by SYNC_STAGES+1 edges.
- R10: `din_snap` equals `pin_in` delayed by SYNC_STAGES+1 edges, whatever the enables and modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_tx_en | input | 1 | Transmit path enable |
| cfg_tx_mode | input | 2 | Transmit pin mode: 00 normal, 01 GPIO, 10/11 act as normal |
| cfg_rx_en | input | 1 | Receive path enable |
| cfg_rx_mode | input | 2 | Receive mode: 00 normal, 01 GPIO, 10 loopback, 11 acts as normal |
| sw_dout | input | DATA_W+3 | Software data-out pattern, laid out like `pin_out` |
| tx_core_data | input | DATA_W | Data byte from the transmitter |
| tx_core_frame | input | 1 | Frame flag from the transmitter |
| rx_core_rd_wait | input | 1 | Read-wait request from the receiver |
| rx_core_wr_wait | input | 1 | Write-wait request from the receiver |
| pin_in | input | DATA_W+3 | Incoming pins: [7:0] data, [8] frame, [9] read-wait, [10] write-wait |
| pin_out | output | DATA_W+3 | Outgoing pins: [7:0] data, [8] frame, [9] read-wait, [10] write-wait |
| to_rx_data | output | DATA_W | Data byte delivered to the receiver |
| to_rx_frame | output | 1 | Frame flag delivered to the receiver |
| to_tx_rd_wait | output | 1 | Read-wait delivered to the transmitter |
| to_tx_wr_wait | output | 1 | Write-wait delivered to the transmitter |
| din_snap | output | DATA_W+3 | Synchronized snapshot of `pin_in` |

## Verification
The bound checker checks the one-edge rules on every cycle. These are the transmit pin sources in normal, reserved and GPIO modes, the receive wait-pin sources, the loopback feed, the zeroing of a disabled path, and the reset values. The paths that cross the synchronizer (the receiver feed in normal and GPIO modes, the wait feedback to the transmitter, and the snapshot) span SYNC_STAGES+1 edges. The bench's queue model checks these, across many mode changes made in the middle of a stream and a reset in the middle of the run.

// File: rtl/linkpin_pkg.sv
package linkpin_pkg;

   typedef enum logic [1:0] {
      TXM_NORMAL = 2'b00,
      TXM_GPIO   = 2'b01,
      TXM_RSV_A  = 2'b10,
      TXM_RSV_B  = 2'b11
   } txm_e;

   typedef enum logic [1:0] {
      RXM_NORMAL = 2'b00,
      RXM_GPIO   = 2'b01,
      RXM_LOOP   = 2'b10,
      RXM_RSV    = 2'b11
   } rxm_e;

   // Reserved transmit codes fall back to normal: only GPIO is special.
   function automatic logic tx_gpio_sel(input logic [1:0] mode);
      return txm_e'(mode) == TXM_GPIO;
   endfunction

   function automatic logic rx_gpio_sel(input logic [1:0] mode);
      return rxm_e'(mode) == RXM_GPIO;
   endfunction

   function automatic logic rx_loop_sel(input logic [1:0] mode);
      return rxm_e'(mode) == RXM_LOOP;
   endfunction

endpackage

// File: rtl/linkpin_sync.sv
module linkpin_sync #(
   parameter int WIDTH  = 11,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[s] <= '0;
               else     chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[s] <= '0;
               else     chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/linkpin_tx_sel.sv
module linkpin_tx_sel
   import linkpin_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              en,
   input  logic [1:0]        mode,
   input  logic [DATA_W-1:0] core_data,
   input  logic              core_frame,
   input  logic [DATA_W:0]   sw_lane,
   input  logic              sync_rd_wait,
   input  logic              sync_wr_wait,
   output logic [DATA_W:0]   nxt_lane,
   output logic              nxt_rd_wait,
   output logic              nxt_wr_wait
);

   localparam int LANE_W = DATA_W + 1;

   logic [LANE_W-1:0] core_lane;
   logic              use_sw;

   assign core_lane = {core_frame, core_data};
   assign use_sw    = tx_gpio_sel(mode);

   always_comb begin
      nxt_lane    = '0;
      nxt_rd_wait = 1'b0;
      nxt_wr_wait = 1'b0;
      if (en) begin
         nxt_lane    = use_sw ? sw_lane : core_lane;
         nxt_rd_wait = sync_rd_wait;
         nxt_wr_wait = sync_wr_wait;
      end
   end

endmodule

// File: rtl/linkpin_rx_sel.sv
module linkpin_rx_sel
   import linkpin_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic            en,
   input  logic [1:0]      mode,
   input  logic [DATA_W:0] pin_lane,
   input  logic [DATA_W:0] loop_lane,
   input  logic            core_rd_wait,
   input  logic            core_wr_wait,
   input  logic [1:0]      sw_waits,
   output logic [DATA_W:0] nxt_lane,
   output logic [1:0]      nxt_waits
);

   logic use_loop;
   logic use_sw;

   assign use_loop = rx_loop_sel(mode);
   assign use_sw   = rx_gpio_sel(mode);

   always_comb begin
      nxt_lane  = '0;
      nxt_waits = 2'b00;
      if (en) begin
         nxt_lane  = use_loop ? loop_lane : pin_lane;
         nxt_waits = use_sw ? sw_waits : {core_wr_wait, core_rd_wait};
      end
   end

endmodule

// File: rtl/linkpin_mux.sv
module linkpin_mux
   import linkpin_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int BUS_W      = DATA_W + 3,
   localparam int FRAME_BIT  = DATA_W,
   localparam int RDW_BIT    = DATA_W + 1,
   localparam int WRW_BIT    = DATA_W + 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_tx_en,
   input  logic [1:0]        cfg_tx_mode,
   input  logic              cfg_rx_en,
   input  logic [1:0]        cfg_rx_mode,
   input  logic [BUS_W-1:0]  sw_dout,
   input  logic [DATA_W-1:0] tx_core_data,
   input  logic              tx_core_frame,
   input  logic              rx_core_rd_wait,
   input  logic              rx_core_wr_wait,
   input  logic [BUS_W-1:0]  pin_in,
   output logic [BUS_W-1:0]  pin_out,
   output logic [DATA_W-1:0] to_rx_data,
   output logic              to_rx_frame,
   output logic              to_tx_rd_wait,
   output logic              to_tx_wr_wait,
   output logic [BUS_W-1:0]  din_snap
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("linkpin_mux: DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("linkpin_mux: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [BUS_W-1:0] pin_sync;
   logic [DATA_W:0]  tx_lane_d;
   logic             tx_rdw_d;
   logic             tx_wrw_d;
   logic [DATA_W:0]  rx_lane_d;
   logic [1:0]       rx_waits_d;

   linkpin_sync #(
      .WIDTH  (BUS_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pin_in),
      .q   (pin_sync)
   );

   linkpin_tx_sel #(
      .DATA_W (DATA_W)
   ) u_tx_sel (
      .en           (cfg_tx_en),
      .mode         (cfg_tx_mode),
      .core_data    (tx_core_data),
      .core_frame   (tx_core_frame),
      .sw_lane      (sw_dout[FRAME_BIT:0]),
      .sync_rd_wait (pin_sync[RDW_BIT]),
      .sync_wr_wait (pin_sync[WRW_BIT]),
      .nxt_lane     (tx_lane_d),
      .nxt_rd_wait  (tx_rdw_d),
      .nxt_wr_wait  (tx_wrw_d)
   );

   linkpin_rx_sel #(
      .DATA_W (DATA_W)
   ) u_rx_sel (
      .en           (cfg_rx_en),
      .mode         (cfg_rx_mode),
      .pin_lane     (pin_sync[FRAME_BIT:0]),
      .loop_lane    ({tx_core_frame, tx_core_data}),
      .core_rd_wait (rx_core_rd_wait),
      .core_wr_wait (rx_core_wr_wait),
      .sw_waits     (sw_dout[WRW_BIT:RDW_BIT]),
      .nxt_lane     (rx_lane_d),
      .nxt_waits    (rx_waits_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pin_out       <= '0;
         to_rx_data    <= '0;
         to_rx_frame   <= 1'b0;
         to_tx_rd_wait <= 1'b0;
         to_tx_wr_wait <= 1'b0;
         din_snap      <= '0;
      end else begin
         pin_out       <= {rx_waits_d, tx_lane_d};
         to_rx_data    <= rx_lane_d[DATA_W-1:0];
         to_rx_frame   <= rx_lane_d[DATA_W];
         to_tx_rd_wait <= tx_rdw_d;
         to_tx_wr_wait <= tx_wrw_d;
         din_snap      <= pin_sync;
      end
   end

endmodule

// File: rtl/linkpin_mux_chk.sv
module linkpin_mux_chk #(
   parameter int DATA_W = 8,
   localparam int BUS_W = DATA_W + 3
) (
   input logic              clk,
   input logic              rst,
   input logic              cfg_tx_en,
   input logic [1:0]        cfg_tx_mode,
   input logic              cfg_rx_en,
   input logic [1:0]        cfg_rx_mode,
   input logic [BUS_W-1:0]  sw_dout,
   input logic [DATA_W-1:0] tx_core_data,
   input logic              tx_core_frame,
   input logic              rx_core_rd_wait,
   input logic              rx_core_wr_wait,
   input logic [BUS_W-1:0]  pin_out,
   input logic [DATA_W-1:0] to_rx_data,
   input logic              to_rx_frame,
   input logic              to_tx_rd_wait,
   input logic              to_tx_wr_wait,
   input logic [BUS_W-1:0]  din_snap
);

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (pin_out == '0 && to_rx_data == '0 && !to_rx_frame &&
               !to_tx_rd_wait && !to_tx_wr_wait && din_snap == '0));

   assert_tx_core_R2: assert property (@(posedge clk) disable iff (rst)
      (cfg_tx_en && cfg_tx_mode != 2'b01) |=>
         pin_out[DATA_W:0] == $past({tx_core_frame, tx_core_data}));

   assert_tx_gpio_R3: assert property (@(posedge clk) disable iff (rst)
      (cfg_tx_en && cfg_tx_mode == 2'b01) |=>
         pin_out[DATA_W:0] == $past(sw_dout[DATA_W:0]));

   assert_tx_off_R4: assert property (@(posedge clk) disable iff (rst)
      !cfg_tx_en |=> (pin_out[DATA_W:0] == '0 && !to_tx_rd_wait && !to_tx_wr_wait));

   assert_rx_core_waits_R5: assert property (@(posedge clk) disable iff (rst)
      (cfg_rx_en && cfg_rx_mode != 2'b01) |=>
         pin_out[DATA_W+2:DATA_W+1] == $past({rx_core_wr_wait, rx_core_rd_wait}));

   assert_rx_gpio_R6: assert property (@(posedge clk) disable iff (rst)
      (cfg_rx_en && cfg_rx_mode == 2'b01) |=>
         pin_out[DATA_W+2:DATA_W+1] == $past(sw_dout[DATA_W+2:DATA_W+1]));

   assert_loopback_R7: assert property (@(posedge clk) disable iff (rst)
      (cfg_rx_en && cfg_rx_mode == 2'b10) |=>
         (to_rx_data == $past(tx_core_data) && to_rx_frame == $past(tx_core_frame)));

   assert_rx_off_R8: assert property (@(posedge clk) disable iff (rst)
      !cfg_rx_en |=> (to_rx_data == '0 && !to_rx_frame &&
                      pin_out[DATA_W+2:DATA_W+1] == 2'b00));

endmodule

bind linkpin_mux linkpin_mux_chk #(.DATA_W(DATA_W)) u_chk (
   .clk             (clk),
   .rst             (rst),
   .cfg_tx_en       (cfg_tx_en),
   .cfg_tx_mode     (cfg_tx_mode),
   .cfg_rx_en       (cfg_rx_en),
   .cfg_rx_mode     (cfg_rx_mode),
   .sw_dout         (sw_dout),
   .tx_core_data    (tx_core_data),
   .tx_core_frame   (tx_core_frame),
   .rx_core_rd_wait (rx_core_rd_wait),
   .rx_core_wr_wait (rx_core_wr_wait),
   .pin_out         (pin_out),
   .to_rx_data      (to_rx_data),
   .to_rx_frame     (to_rx_frame),
   .to_tx_rd_wait   (to_tx_rd_wait),
   .to_tx_wr_wait   (to_tx_wr_wait),
   .din_snap        (din_snap)
);

// File: tb/linkpin_mux_test.sv
module linkpin_mux_test;

   localparam int DW = 8;
   localparam int BW = DW + 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_tx_en = 1'b0;
   logic [1:0]    cfg_tx_mode = 2'b00;
   logic          cfg_rx_en = 1'b0;
   logic [1:0]    cfg_rx_mode = 2'b00;
   logic [BW-1:0] sw_dout = '0;
   logic [DW-1:0] tx_core_data = '0;
   logic          tx_core_frame = 1'b0;
   logic          rx_core_rd_wait = 1'b0;
   logic          rx_core_wr_wait = 1'b0;
   logic [BW-1:0] pin_in = '0;
   logic [BW-1:0] pin_out;
   logic [DW-1:0] to_rx_data;
   logic          to_rx_frame;
   logic          to_tx_rd_wait;
   logic          to_tx_wr_wait;
   logic [BW-1:0] din_snap;

   always #5 clk = ~clk;

   linkpin_mux #(.DATA_W(DW), .SYNC_STAGES(2)) uut (
      .clk (clk), .rst (rst),
      .cfg_tx_en (cfg_tx_en), .cfg_tx_mode (cfg_tx_mode),
      .cfg_rx_en (cfg_rx_en), .cfg_rx_mode (cfg_rx_mode),
      .sw_dout (sw_dout),
      .tx_core_data (tx_core_data), .tx_core_frame (tx_core_frame),
      .rx_core_rd_wait (rx_core_rd_wait), .rx_core_wr_wait (rx_core_wr_wait),
      .pin_in (pin_in), .pin_out (pin_out),
      .to_rx_data (to_rx_data), .to_rx_frame (to_rx_frame),
      .to_tx_rd_wait (to_tx_rd_wait), .to_tx_wr_wait (to_tx_wr_wait),
      .din_snap (din_snap)
   );

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   // Reference model: pin history queue of depth 2 (the synchronizer), then one output flop.
   logic [BW-1:0] hist [$];
   logic [8:0]    e_txlane;
   logic [1:0]    e_rxwaits;
   logic [8:0]    e_rxlane;
   logic [1:0]    e_txwaits;
   logic [BW-1:0] e_snap;
   string         t_tx, t_rx, t_tw;

   initial begin
      hist = '{11'h0, 11'h0};
      e_txlane = '0; e_rxwaits = '0; e_rxlane = '0; e_txwaits = '0; e_snap = '0;
      t_tx = "R1"; t_rx = "R1"; t_tw = "R1";
   end

   always @(posedge clk) begin
      logic [BW-1:0] old;
      if (rst) begin
         hist = '{11'h0, 11'h0};
         e_txlane = '0; e_rxwaits = '0; e_rxlane = '0; e_txwaits = '0; e_snap = '0;
         t_tx = "R1"; t_rx = "R1"; t_tw = "R1";
      end else begin
         old = hist.pop_front();
         hist.push_back(pin_in);
         e_snap = old;
         if (!cfg_tx_en) begin
            e_txlane = '0; e_txwaits = '0; t_tx = "R4"; t_tw = "R4";
         end else begin
            t_tw = "R9";
            e_txwaits = old[10:9];
            if (cfg_tx_mode == 2'b01) begin e_txlane = sw_dout[8:0]; t_tx = "R3"; end
            else begin e_txlane = {tx_core_frame, tx_core_data}; t_tx = "R2"; end
         end
         if (!cfg_rx_en) begin
            e_rxwaits = '0; e_rxlane = '0; t_rx = "R8";
         end else begin
            case (cfg_rx_mode)
               2'b01: begin e_rxwaits = sw_dout[10:9]; e_rxlane = old[8:0]; t_rx = "R6"; end
               2'b10: begin e_rxwaits = {rx_core_wr_wait, rx_core_rd_wait};
                            e_rxlane = {tx_core_frame, tx_core_data}; t_rx = "R7"; end
               default: begin e_rxwaits = {rx_core_wr_wait, rx_core_rd_wait};
                              e_rxlane = old[8:0]; t_rx = "R5"; end
            endcase
         end
      end
   end

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         cmp(t_tx, "pin_out[8:0]", int'(pin_out[8:0]), int'(e_txlane));
         cmp(t_rx, "pin_out[10:9]", int'(pin_out[10:9]), int'(e_rxwaits));
         cmp(t_rx, "to_rx lane", int'({to_rx_frame, to_rx_data}), int'(e_rxlane));
         cmp(t_tw, "to_tx waits", int'({to_tx_wr_wait, to_tx_rd_wait}), int'(e_txwaits));
         cmp(rst ? "R1" : "R10", "din_snap", int'(din_snap), int'(e_snap));
      end
   end

   task automatic run(input int n, input bit te, input logic [1:0] tm,
                      input bit re, input logic [1:0] rm);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cfg_tx_en = te; cfg_tx_mode = tm; cfg_rx_en = re; cfg_rx_mode = rm;
         sw_dout = BW'($urandom);
         tx_core_data = DW'($urandom);
         tx_core_frame = 1'($urandom);
         rx_core_rd_wait = 1'($urandom);
         rx_core_wr_wait = 1'($urandom);
         pin_in = BW'($urandom);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      run(40, 1, 2'b00, 1, 2'b00);   // R2 R5 R9 R10
      run(30, 1, 2'b10, 1, 2'b11);   // reserved codes act as normal: R2 R5
      run(30, 1, 2'b11, 1, 2'b01);   // R2 R6
      run(30, 1, 2'b01, 1, 2'b10);   // R3 R7
      run(30, 0, 2'b00, 1, 2'b10);   // loopback with transmit off: R4 R7
      run(30, 1, 2'b01, 0, 2'b01);   // R3 R8
      run(20, 0, 2'b01, 0, 2'b10);   // R4 R8
      @(negedge clk); rst = 1'b1;    // reset in mid-run: R1
      run(2, 1, 2'b01, 1, 2'b01);
      @(negedge clk); rst = 1'b0;
      for (int k = 0; k < 800; k++)
         run(1, 1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom));
      run(5, 1, 2'b00, 1, 2'b00);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         compared++;
         mismatched++;
         $display("FAIL R1 watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule